// File: doc/BRIEF.md
# Console Serial Port with Register Bus

This block is a console serial port that sits on a simple 16-bit word register bus. It answers at a base address set by a parameter inside the top 8 KB of the address space, where all I/O registers live. Through four word registers, software can check and clear receive completion, collect received characters together with error flags, check transmitter readiness, and send characters. A character frame has one start bit, eight data bits sent least significant bit first, an optional even parity bit, and one stop bit. Strap-style inputs set the bit rate for each direction, choose between common-speed and split-speed operation, enable parity, enable the error byte, and enable line-break handling.

The block raises one interrupt request and presents a fixed vector with it. The receive vector is 060 (octal) and the transmit vector is 064 (octal). When both sources are pending, receive has priority. Software can hold the transmit line at space to send a break. A break arriving on the receive line can drive a halt request to the processor.

Top module: `con_serial`

## Requirements
- R1: The registers respond only when addr_i[15:13] are all one, addr_i[12:3] equal the same bits of BASE_ADDR (default octal 177560), and addr_i[0] is zero. addr_i[2:1] selects the register: 0 = RX_CSR, 1 = RX_BUF, 2 = TX_CSR, 3 = TX_BUF. Any read that does not match returns 0, and any write that does not match changes nothing. TX_BUF always reads as 0.
- R2: RX_CSR bit 7 is receive-done and is read-only. RX_CSR bit 6 is receive interrupt enable, can be read and written, and is written from the low byte when be_i[0] is set. All other RX_CSR bits read 0.
- R3: A received frame (a low start bit, 8 data bits least significant bit first, an optional parity bit, a stop bit) places its data in RX_BUF[7:0] and sets receive-done.
- R4: A read of RX_BUF clears receive-done. If a frame completes in the same cycle as that read, receive-done stays set, the read returns the previous character, and no overrun is recorded.
- R5: When err_flag_en_i is 1, RX_BUF[15:12] carries four flags: bit 15 is the OR of the other three, bit 14 is overrun (a frame completed while receive-done was still set), bit 13 is framing error (stop bit sampled low), and bit 12 is parity error. When err_flag_en_i is 0, RX_BUF[15:8] reads 0. All flags are replaced each time a frame completes.
- R6: With par_gen_i set, the transmitter sends an even parity bit (the XOR of the data bits) after the data, and the receiver expects one. With par_gen_i and par_chk_i both set, a mismatched parity bit sets the parity error flag.
- R7: A bit lasts BASE_DIV*(16-code) clock cycles, where BASE_DIV defaults to 8. With split_i = 0, both directions use rx_baud_i. With split_i = 1, the transmitter uses tx_baud_i instead.
- R8: Writing TX_BUF with be_i[0] set while TX_CSR bit 7 (ready) is 1 clears ready and sends the low byte on tx_o. Ready returns to 1 after the full stop bit. Writes to TX_BUF while ready is 0, or writes without be_i[0], are dropped.
- R9: With brk_en_i set, TX_CSR bit 0 holds tx_o low. With brk_en_i clear, TX_CSR bit 0 has no effect on tx_o. TX_CSR bit 6 is transmit interrupt enable.
- R10: irq_o is high when (receive-done and receive enable) or (ready and transmit enable). vec_o is octal 060 for receive and octal 064 for transmit, with receive taking priority. vec_o is 0 when no request is pending.
- R11: A received break is a frame with all-zero data and a low stop bit. With halt_on_brk_i set, a received break raises halt_o, which stays high until the receive line returns high. With halt_on_brk_i clear, halt_o stays 0.
- R12: After reset, RX_CSR reads 0, TX_CSR reads 0x0080, tx_o is 1, and irq_o, vec_o and halt_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Bus byte address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enables for the write |
| wr_i | input | 1 | Write strobe, one cycle |
| rd_i | input | 1 | Read strobe, one cycle |
| rdata_o | output | 16 | Read data, combinational |
| rx_i | input | 1 | Serial receive line, idles high |
| tx_o | output | 1 | Serial transmit line, idles high |
| rx_baud_i | input | 4 | Receive rate code |
| tx_baud_i | input | 4 | Transmit rate code, used in split mode |
| split_i | input | 1 | Split-speed select |
| par_gen_i | input | 1 | Parity bit present in frame |
| par_chk_i | input | 1 | Check received parity |
| err_flag_en_i | input | 1 | Return error flags in RX_BUF high byte |
| brk_en_i | input | 1 | Allow software break |
| halt_on_brk_i | input | 1 | Halt request on received break |
| irq_o | output | 1 | Interrupt request |
| vec_o | output | 8 | Vector of the pending request |
| halt_o | output | 1 | Halt request |

## Verification
A received frame can complete in the same cycle that software reads RX_BUF. In that cycle the frame's setting of receive-done and the read's clearing of it meet, and the overrun decision depends on which one wins. The bench first measures how many cycles pass from a start bit to the rise of the interrupt. It then sends a second frame while the first character is still unread, and pulses the RX_BUF read exactly in the completing cycle. The outcome is judged at the ports: the coincident read must return the old character, receive-done must still be set afterwards, and the next read must return the new character with no overrun flag.

// File: rtl/con_pkg.sv
package con_pkg;
  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
  } rx_state_e;

  localparam logic [1:0] SEL_RCSR = 2'd0;
  localparam logic [1:0] SEL_RBUF = 2'd1;
  localparam logic [1:0] SEL_XCSR = 2'd2;
  localparam logic [1:0] SEL_XBUF = 2'd3;

  localparam logic [7:0] VEC_RX = 8'o060;
  localparam logic [7:0] VEC_TX = 8'o064;

  typedef struct packed {
    logic ovr;
    logic fe;
    logic pe;
  } rx_err_t;
endpackage

// File: rtl/con_baud_sel.sv
module con_baud_sel #(
  parameter int BASE_DIV = 8,
  parameter int PW = $clog2(BASE_DIV * 16 + 1)
) (
  input  logic [3:0]    rx_code_i,
  input  logic [3:0]    tx_code_i,
  input  logic          split_i,
  output logic [PW-1:0] rx_per_o,
  output logic [PW-1:0] tx_per_o
);
  function automatic logic [PW-1:0] code_per(input logic [3:0] c);
    code_per = PW'(BASE_DIV * (16 - int'(c)));
  endfunction

  assign rx_per_o = code_per(rx_code_i);
  assign tx_per_o = split_i ? code_per(tx_code_i) : code_per(rx_code_i);
endmodule

// File: rtl/con_tx.sv
module con_tx #(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [7:0]    data_i,
  input  logic          par_en_i,
  input  logic [PW-1:0] per_i,
  output logic          line_o,
  output logic          done_o
);
  logic [10:0]   sh;
  logic [3:0]    left;
  logic [PW-1:0] cnt;
  logic          busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh     <= '1;
      left   <= '0;
      cnt    <= '0;
      busy   <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy) begin
        if (start_i) begin
          busy <= 1'b1;
          cnt  <= per_i - 1'b1;
          if (par_en_i) begin
            sh   <= {1'b1, ^data_i, data_i, 1'b0};
            left <= 4'd10;
          end else begin
            sh   <= {2'b11, data_i, 1'b0};
            left <= 4'd9;
          end
        end
      end else if (cnt == '0) begin
        cnt <= per_i - 1'b1;
        if (left == '0) begin
          busy   <= 1'b0;
          done_o <= 1'b1;
        end else begin
          sh   <= {1'b1, sh[10:1]};
          left <= left - 1'b1;
        end
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign line_o = busy ? sh[0] : 1'b1;
endmodule

// File: rtl/con_rx.sv
module con_rx
  import con_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_i,
  input  logic [PW-1:0] per_i,
  input  logic          par_en_i,
  input  logic          par_chk_i,
  output logic          valid_o,
  output logic [7:0]    data_o,
  output logic          fe_o,
  output logic          pe_o,
  output logic          brk_o
);
  rx_state_e     state;
  logic          s1, s2, perr;
  logic [PW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1 <= 1'b1; s2 <= 1'b1;
      state <= RX_IDLE;
      cnt <= '0; idx <= '0; sh <= '0; perr <= 1'b0;
      valid_o <= 1'b0; data_o <= '0; fe_o <= 1'b0; pe_o <= 1'b0; brk_o <= 1'b0;
    end else begin
      s1 <= line_i;
      s2 <= s1;
      valid_o <= 1'b0;
      unique case (state)
        RX_IDLE: if (!s2) begin
          state <= RX_START;
          cnt   <= (per_i >> 1) - 1'b1;
        end
        RX_START: if (cnt == '0) begin
          state <= s2 ? RX_IDLE : RX_DATA;
          cnt   <= per_i - 1'b1;
          idx   <= '0;
          perr  <= 1'b0;
        end else cnt <= cnt - 1'b1;
        RX_DATA: if (cnt == '0) begin
          sh  <= {s2, sh[7:1]};
          cnt <= per_i - 1'b1;
          idx <= idx + 1'b1;
          if (idx == 3'd7) state <= par_en_i ? RX_PAR : RX_STOP;
        end else cnt <= cnt - 1'b1;
        RX_PAR: if (cnt == '0) begin
          perr  <= par_chk_i & (s2 ^ (^sh));
          cnt   <= per_i - 1'b1;
          state <= RX_STOP;
        end else cnt <= cnt - 1'b1;
        RX_STOP: if (cnt == '0) begin
          valid_o <= 1'b1;
          data_o  <= sh;
          fe_o    <= ~s2;
          pe_o    <= perr;
          brk_o   <= ~s2 & (sh == '0);
          state   <= s2 ? RX_IDLE : RX_HOLD;
        end else cnt <= cnt - 1'b1;
        RX_HOLD: if (s2) begin
          brk_o <= 1'b0;
          state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/con_serial.sv
module con_serial
  import con_pkg::*;
#(
  parameter logic [15:0] BASE_ADDR = 16'o177560,
  parameter int          BASE_DIV  = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] addr_i,
  input  logic [15:0] wdata_i,
  input  logic [1:0]  be_i,
  input  logic        wr_i,
  input  logic        rd_i,
  output logic [15:0] rdata_o,
  input  logic        rx_i,
  output logic        tx_o,
  input  logic [3:0]  rx_baud_i,
  input  logic [3:0]  tx_baud_i,
  input  logic        split_i,
  input  logic        par_gen_i,
  input  logic        par_chk_i,
  input  logic        err_flag_en_i,
  input  logic        brk_en_i,
  input  logic        halt_on_brk_i,
  output logic        irq_o,
  output logic [7:0]  vec_o,
  output logic        halt_o
);
  localparam int PW = $clog2(BASE_DIV * 16 + 1);

  logic [PW-1:0] rx_per, tx_per;
  logic          hit, rbuf_rd, lo_wr, tx_start, tx_done, tx_line;
  logic [1:0]    sel;
  logic          rx_valid, rx_fe, rx_pe, rx_brk;
  logic [7:0]    rx_byte;

  logic          rx_done, rx_ie, tx_ie, tx_brk, tx_rdy;
  logic [7:0]    rx_data;
  rx_err_t       rx_err;
  logic [3:0]    err_hi;
  logic          rx_irq, tx_irq;
  logic          unused_bits;

  assign unused_bits = ^{wdata_i[15:8], wdata_i[5:1], wdata_i[7], be_i[1]};

  con_baud_sel #(.BASE_DIV(BASE_DIV), .PW(PW)) u_baud (
    .rx_code_i(rx_baud_i), .tx_code_i(tx_baud_i), .split_i(split_i),
    .rx_per_o(rx_per), .tx_per_o(tx_per)
  );

  con_tx #(.PW(PW)) u_tx (
    .clk_i, .rst_ni, .start_i(tx_start), .data_i(wdata_i[7:0]),
    .par_en_i(par_gen_i), .per_i(tx_per), .line_o(tx_line), .done_o(tx_done)
  );

  con_rx #(.PW(PW)) u_rx (
    .clk_i, .rst_ni, .line_i(rx_i), .per_i(rx_per), .par_en_i(par_gen_i),
    .par_chk_i(par_chk_i), .valid_o(rx_valid), .data_o(rx_byte),
    .fe_o(rx_fe), .pe_o(rx_pe), .brk_o(rx_brk)
  );

  assign hit      = (addr_i[15:13] == 3'b111) && (addr_i[12:3] == BASE_ADDR[12:3]) && !addr_i[0];
  assign sel      = addr_i[2:1];
  assign rbuf_rd  = hit && rd_i && (sel == SEL_RBUF);
  assign lo_wr    = hit && wr_i && be_i[0];
  assign tx_start = lo_wr && (sel == SEL_XBUF) && tx_rdy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_done <= 1'b0; rx_ie <= 1'b0; rx_data <= '0; rx_err <= '0;
      tx_ie <= 1'b0; tx_brk <= 1'b0; tx_rdy <= 1'b1;
    end else begin
      if (rx_valid) begin
        rx_done    <= 1'b1;
        rx_data    <= rx_byte;
        rx_err.ovr <= rx_done & ~rbuf_rd;
        rx_err.fe  <= rx_fe;
        rx_err.pe  <= rx_pe;
      end else if (rbuf_rd) begin
        rx_done <= 1'b0;
      end
      if (lo_wr && sel == SEL_RCSR) rx_ie <= wdata_i[6];
      if (lo_wr && sel == SEL_XCSR) begin
        tx_ie  <= wdata_i[6];
        tx_brk <= wdata_i[0];
      end
      if (tx_start)     tx_rdy <= 1'b0;
      else if (tx_done) tx_rdy <= 1'b1;
    end
  end

  assign err_hi = err_flag_en_i ? {|rx_err, rx_err.ovr, rx_err.fe, rx_err.pe} : 4'b0;

  always_comb begin
    rdata_o = '0;
    if (hit && rd_i) begin
      unique case (sel)
        SEL_RCSR: rdata_o = {8'b0, rx_done, rx_ie, 6'b0};
        SEL_RBUF: rdata_o = {err_hi, 4'b0, rx_data};
        SEL_XCSR: rdata_o = {8'b0, tx_rdy, tx_ie, 5'b0, tx_brk};
        default:  rdata_o = '0;
      endcase
    end
  end

  assign rx_irq = rx_done & rx_ie;
  assign tx_irq = tx_rdy & tx_ie;
  assign irq_o  = rx_irq | tx_irq;
  assign vec_o  = rx_irq ? VEC_RX : (tx_irq ? VEC_TX : 8'h00);
  assign tx_o   = (tx_brk & brk_en_i) ? 1'b0 : tx_line;
  assign halt_o = halt_on_brk_i & rx_brk;
endmodule

// File: rtl/con_serial_chk.sv
module con_serial_chk #(
  parameter logic [15:0] BASE_ADDR = 16'o177560
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_i,
  input logic        wr_i,
  input logic        rd_i,
  input logic [1:0]  be_i,
  input logic [15:0] rdata_o,
  input logic        irq_o,
  input logic [7:0]  vec_o,
  input logic        halt_o,
  input logic        halt_on_brk_i,
  input logic        err_flag_en_i,
  input logic        brk_en_i,
  input logic        tx_o,
  input logic        rx_done,
  input logic        rx_ie,
  input logic        tx_rdy,
  input logic        tx_brk,
  input logic        rx_valid
);
  logic match;
  assign match = (addr_i[15:13] == 3'b111) && (addr_i[12:3] == BASE_ADDR[12:3]) && !addr_i[0];

  p_miss_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !match |-> rdata_o == 16'h0);

  p_rd_clears_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && rd_i && addr_i[2:1] == 2'd1 && !rx_valid) |=> !rx_done);

  p_frame_sets_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid |=> rx_done);

  p_hi_byte_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_flag_en_i && match && rd_i && addr_i[2:1] == 2'd1) |-> rdata_o[15:8] == 8'h0);

  p_write_clears_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && wr_i && be_i[0] && addr_i[2:1] == 2'd3 && tx_rdy) |=> !tx_rdy);

  p_idle_mark_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_rdy && !(tx_brk && brk_en_i)) |-> tx_o);

  p_rx_vector_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done && rx_ie) |-> (irq_o && vec_o == 8'o060));

  p_quiet_vector_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> vec_o == 8'h00);

  p_halt_option_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> halt_on_brk_i);
endmodule

bind con_serial con_serial_chk #(.BASE_ADDR(BASE_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
  .be_i(be_i), .rdata_o(rdata_o), .irq_o(irq_o), .vec_o(vec_o), .halt_o(halt_o),
  .halt_on_brk_i(halt_on_brk_i), .err_flag_en_i(err_flag_en_i),
  .brk_en_i(brk_en_i), .tx_o(tx_o), .rx_done(rx_done), .rx_ie(rx_ie),
  .tx_rdy(tx_rdy), .tx_brk(tx_brk), .rx_valid(rx_valid)
);

// File: tb/tb_con_serial.sv
`timescale 1ns/1ps
module tb_con_serial;
  localparam logic [15:0] A_RCSR = 16'o177560;
  localparam logic [15:0] A_RBUF = 16'o177562;
  localparam logic [15:0] A_XCSR = 16'o177564;
  localparam logic [15:0] A_XBUF = 16'o177566;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0, wdata = '0, rdata;
  logic [1:0] be = '0;
  logic wr = 1'b0, rd = 1'b0, rx = 1'b1, tx;
  logic [3:0] rx_baud = 4'd15, tx_baud = 4'd12;
  logic split = 0, par_gen = 0, par_chk = 0, err_en = 1, brk_en = 0, halt_opt = 0;
  logic irq, halt;
  logic [7:0] vec;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  int mon_per = 8;
  bit mon_par = 0, mon_en = 1, done_run = 0;

  always #2 clk = ~clk;

  con_serial dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .be_i(be),
    .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .rx_i(rx), .tx_o(tx),
    .rx_baud_i(rx_baud), .tx_baud_i(tx_baud), .split_i(split),
    .par_gen_i(par_gen), .par_chk_i(par_chk), .err_flag_en_i(err_en),
    .brk_en_i(brk_en), .halt_on_brk_i(halt_opt), .irq_o(irq), .vec_o(vec),
    .halt_o(halt)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [15:0] d, input logic [1:0] b);
    @(negedge clk); addr = a; wdata = d; be = b; wr = 1'b1;
    @(negedge clk); wr = 1'b0; addr = '0; be = '0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0; addr = '0;
  endtask

  task automatic send_tx(input logic [7:0] b);
    exp_q.push_back(b);
    bus_wr(A_XBUF, {8'h00, b}, 2'b01);
  endtask

  task automatic send_rx(input logic [7:0] b, input int per, input bit use_par, input bit pbit, input bit stop);
    @(negedge clk); rx = 1'b0;
    repeat (per) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rx = b[i]; repeat (per) @(negedge clk); end
    if (use_par) begin rx = pbit; repeat (per) @(negedge clk); end
    rx = stop; repeat (per) @(negedge clk);
    rx = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_tx_idle();
    logic [15:0] d;
    for (int i = 0; i < 400; i++) begin
      bus_rd(A_XCSR, d);
      if (d[7] && exp_q.size() == 0) break;
    end
    repeat (20) @(negedge clk);
  endtask

  // scoreboard monitor: decodes tx and pops expected bytes
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && tx === 1'b0) begin
        logic [7:0] got;
        logic pb, sb, st;
        int p;
        p = mon_per;
        repeat (p / 2) @(negedge clk);
        st = tx;
        for (int i = 0; i < 8; i++) begin repeat (p) @(negedge clk); got[i] = tx; end
        pb = 1'b0;
        if (mon_par) begin repeat (p) @(negedge clk); pb = tx; end
        repeat (p) @(negedge clk);
        sb = tx;
        chk("R8", "tx start bit", {15'b0, st}, 16'h0);
        chk("R8", "tx stop bit", {15'b0, sb}, 16'h1);
        if (mon_par) chk("R6", "tx parity bit", {15'b0, pb}, {15'b0, ^got});
        if (exp_q.size() == 0) chk("R8", "unexpected tx frame", {8'h0, got}, 16'hFFFF);
        else chk("R7", "tx frame data", {8'h0, got}, {8'h0, exp_q.pop_front()});
      end
    end
  end

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    int kf;
    repeat (3) @(negedge clk);
    chk("R12", "tx idle in reset", {15'b0, tx}, 16'h1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R12 reset state
    bus_rd(A_RCSR, d); chk("R12", "RX_CSR after reset", d, 16'h0000);
    bus_rd(A_XCSR, d); chk("R12", "TX_CSR after reset", d, 16'h0080);
    chk("R12", "irq/vec/halt after reset", {7'b0, irq, vec}, 16'h0);
    chk("R12", "halt after reset", {15'b0, halt}, 16'h0);

    // R1 decode, R2 RX_CSR
    bus_wr(16'o157560, 16'h0040, 2'b11);
    bus_wr(16'o177570, 16'h0040, 2'b11);
    bus_wr(16'o177561, 16'h0040, 2'b11);
    bus_rd(A_RCSR, d); chk("R1", "misses do not write", d, 16'h0000);
    bus_rd(16'o177574, d); chk("R1", "read outside base", d, 16'h0000);
    bus_rd(A_XBUF, d); chk("R1", "TX_BUF reads zero", d, 16'h0000);
    bus_wr(A_RCSR, 16'hFFFF, 2'b11);
    bus_rd(A_RCSR, d); chk("R2", "only enable bit writable", d, 16'h0040);
    bus_wr(A_RCSR, 16'h0000, 2'b11);

    // R8 transmit, common speed R7
    send_tx(8'hA5);
    bus_rd(A_XCSR, d); chk("R8", "ready cleared by write", d, 16'h0000);
    wait_tx_idle();
    chk("R8", "ready back, queue drained", {15'b0, exp_q.size() == 0}, 16'h1);
    bus_wr(A_XBUF, 16'h003C, 2'b10);
    bus_rd(A_XCSR, d); chk("R8", "high-byte-only write dropped", d, 16'h0080);
    repeat (40) @(negedge clk);
    send_tx(8'h11);
    bus_wr(A_XBUF, 16'h0022, 2'b01);
    wait_tx_idle();
    repeat (100) @(negedge clk);
    chk("R8", "write while busy dropped", exp_q.size(), 16'h0);

    // R7 split speed
    split = 1; tx_baud = 4'd14; mon_per = 16;
    send_tx(8'h5A);
    wait_tx_idle();
    chk("R7", "split-speed frame consumed", exp_q.size(), 16'h0);
    // R6 parity generation
    par_gen = 1; mon_par = 1;
    send_tx(8'h07);
    wait_tx_idle();
    chk("R6", "parity frame consumed", exp_q.size(), 16'h0);
    par_gen = 0; mon_par = 0; split = 0; mon_per = 8;

    // R3 receive, R4 clear
    send_rx(8'hC3, 8, 0, 0, 1);
    bus_rd(A_RCSR, d); chk("R3", "done after frame", d, 16'h0080);
    bus_rd(A_RBUF, d); chk("R3", "received byte", d, 16'h00C3);
    bus_rd(A_RCSR, d); chk("R4", "read clears done", d, 16'h0000);

    // R5 overrun
    send_rx(8'h12, 8, 0, 0, 1);
    send_rx(8'h34, 8, 0, 0, 1);
    bus_rd(A_RBUF, d); chk("R5", "overrun flags", d, 16'hC034);
    err_en = 0;
    send_rx(8'h55, 8, 0, 0, 1);
    send_rx(8'h66, 8, 0, 0, 1);
    bus_rd(A_RBUF, d); chk("R5", "flags hidden when disabled", d, 16'h0066);
    err_en = 1;
    send_rx(8'h81, 8, 0, 0, 0);
    bus_rd(A_RBUF, d); chk("R5", "framing flag", d, 16'hA081);

    // R6 parity check
    par_gen = 1; par_chk = 1;
    send_rx(8'h07, 8, 1, 0, 1);
    bus_rd(A_RBUF, d); chk("R6", "bad parity flagged", d, 16'h9007);
    send_rx(8'h07, 8, 1, 1, 1);
    bus_rd(A_RBUF, d); chk("R6", "good parity clean", d, 16'h0007);
    par_chk = 0;
    send_rx(8'h07, 8, 1, 0, 1);
    bus_rd(A_RBUF, d); chk("R6", "check disabled", d, 16'h0007);
    par_gen = 0;

    // R4 coincident read and frame completion
    bus_wr(A_RCSR, 16'h0040, 2'b01);
    repeat (20) @(negedge clk);
    kf = 0;
    fork
      send_rx(8'h61, 8, 0, 0, 1);
      begin
        do begin @(negedge clk); kf++; end while (!irq && kf < 500);
      end
    join
    repeat (30) @(negedge clk);
    fork
      send_rx(8'h62, 8, 0, 0, 1);
      begin
        repeat (kf - 1) @(negedge clk);
        addr = A_RBUF; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd = 1'b0; addr = '0;
      end
    join
    chk("R4", "coincident read returns old char", d, 16'h0061);
    bus_rd(A_RCSR, d); chk("R4", "done survives coincident read", d, 16'h00C0);
    bus_rd(A_RBUF, d); chk("R4", "new char without overrun", d, 16'h0062);

    // R10 interrupts
    send_rx(8'h44, 8, 0, 0, 1);
    chk("R10", "rx request vector", {7'b0, irq, vec}, 16'h0130);
    bus_wr(A_XCSR, 16'h0040, 2'b01);
    chk("R10", "rx wins over tx", {7'b0, irq, vec}, 16'h0130);
    bus_rd(A_RBUF, d);
    @(negedge clk);
    chk("R10", "tx request vector", {7'b0, irq, vec}, 16'h0134);
    bus_wr(A_XCSR, 16'h0000, 2'b01);
    bus_wr(A_RCSR, 16'h0000, 2'b01);
    @(negedge clk);
    chk("R10", "no request", {7'b0, irq, vec}, 16'h0000);

    // R9 break generation
    mon_en = 0; brk_en = 1;
    bus_wr(A_XCSR, 16'h0001, 2'b01);
    repeat (2) @(negedge clk);
    chk("R9", "break holds line low", {15'b0, tx}, 16'h0);
    bus_wr(A_XCSR, 16'h0000, 2'b01);
    @(negedge clk);
    chk("R9", "line released", {15'b0, tx}, 16'h1);
    brk_en = 0;
    bus_wr(A_XCSR, 16'h0001, 2'b01);
    repeat (5) @(negedge clk);
    chk("R9", "break ignored when disabled", {15'b0, tx}, 16'h1);
    bus_wr(A_XCSR, 16'h0000, 2'b01);
    mon_en = 1;

    // R11 halt on break
    @(negedge clk); rx = 1'b0;
    repeat (100) @(negedge clk);
    chk("R11", "no halt without option", {15'b0, halt}, 16'h0);
    rx = 1'b1; repeat (10) @(negedge clk);
    bus_rd(A_RBUF, d); chk("R11", "break frame content", d, 16'hA000);
    halt_opt = 1;
    @(negedge clk); rx = 1'b0;
    repeat (100) @(negedge clk);
    chk("R11", "halt on break", {15'b0, halt}, 16'h1);
    rx = 1'b1; repeat (6) @(negedge clk);
    chk("R11", "halt drops at mark", {15'b0, halt}, 16'h0);
    bus_rd(A_RBUF, d);
    halt_opt = 0;

    repeat (20) @(negedge clk);
    chk("R8", "scoreboard empty at end", exp_q.size(), 16'h0);
    finish_run();
  end
endmodule